// File: doc/BRIEF.md
# SAR ADC Serial Read Controller

This block is the host-side sequencer for a small successive-approximation converter. The converter has a chip-select, a serial clock and a serial data line. A one-clock start request makes the controller drop chip-select and hold the serial clock high for a setup interval. It then runs the serial clock at a programmable half period, counted in system clocks. The first two serial clock periods make up the rest of the acquisition window. The third falling edge puts the converter into hold. After that the controller runs one conversion period for each result bit plus one, and captures the data bits MSB first on rising edges.

When the last conversion period ends, chip-select goes high and the result appears with a one-clock valid strobe. The block then stays busy through a quiet tail before it accepts the next request. Three values are taken from the configuration inputs when the request is accepted: the serial clock half period, the resolution, and the tail length. The setup interval is computed at that moment from the requested minimum acquisition time. The minimum acquisition time depends on the supply and the resolution, so it is a run-time input.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are: cs_no high, sclk_o high, busy_o low, valid_o low and data_o zero.
- R2: sclk_o is high in every cycle where cs_no is high. Each low phase of sclk_o lasts h system clocks, where h is half_i, or 1 when half_i is 0.
- R3: From the fall of cs_no to the first fall of sclk_o, there are S cycles with sclk_o high. S is min_samp_i - 4h when that value is larger than h, and h otherwise. So S + 4h is always at least min_samp_i.
- R4: Resolution encoding on res_i: 0 selects 12 bits, 1 selects 10 bits, and 2 or 3 selects 8 bits. A cycle with B bits has exactly B + 3 falling edges of sclk_o: two for acquisition, the hold edge, then B more.
- R5: The controller samples sdo_i on the rising sclk_o edge of conversion periods 2 through B+1. Conversion period k begins on falling edge k+2. The first sample is the MSB. data_o holds the B bits right-justified, with the upper bits zero.
- R6: cs_no stays low for S + 2h(B+3) cycles. valid_o is high for exactly one cycle, the first cycle with cs_no high again, and data_o carries the new result in that cycle.
- R7: After cs_no rises, busy_o stays high for max(tail_i, h) more cycles and then falls.
- R8: A start_i pulse while busy_o is high is ignored. No second chip-select fall happens, and cs_no stays high after busy_o falls.
- R9: Changes to half_i, res_i, tail_i or min_samp_i during a cycle do not alter that cycle's timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin one conversion cycle |
| res_i | input | 2 | Resolution select (0:12, 1:10, 2/3:8 bits) |
| half_i | input | DIV_W | Serial clock half period in system clocks |
| min_samp_i | input | SAMP_W | Minimum acquisition time in system clocks |
| tail_i | input | TAIL_W | Minimum quiet tail in system clocks |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip-select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | High from the accepted request until the tail ends |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 12 | Right-justified conversion result |

## Verification
The hardest case to reach is a request, or a configuration change, that lands in the middle of a running cycle. The sweep reaches it by disturbing chosen runs right after the first serial clock fall. In those runs the bench raises start_i and rewrites every configuration input. It then checks that the timing and data of the cycle still match values computed from the original settings. A second hard case is the boundary between the setup formula's two branches. The sweep combines minimum acquisition times below, near and above four half periods.

// File: rtl/sar_rd_pkg.sv
`timescale 1ns/1ps
package sar_rd_pkg;
  localparam int MAX_BITS = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_TAIL} sar_st_e;

  function automatic logic [3:0] res_bits(input logic [1:0] res);
    case (res)
      2'd0:    res_bits = 4'd12;
      2'd1:    res_bits = 4'd10;
      default: res_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/sar_cfg.sv
`timescale 1ns/1ps
module sar_cfg #(
  parameter int DIV_W  = 8,
  parameter int SAMP_W = 10,
  parameter int TAIL_W = 8,
  parameter int CNT_W  = 12
) (
  input  logic [DIV_W-1:0]  half_i,
  input  logic [SAMP_W-1:0] min_samp_i,
  input  logic [TAIL_W-1:0] tail_i,
  output logic [CNT_W-1:0]  half_o,
  output logic [CNT_W-1:0]  setup_o,
  output logic [CNT_W-1:0]  tail_o
);
  logic [CNT_W-1:0] h, acq, ms, diff, tl;

  always_comb begin
    h    = (half_i == '0) ? CNT_W'(1) : CNT_W'(half_i);
    acq  = h << 2;  // two full periods after the setup interval
    ms   = CNT_W'(min_samp_i);
    diff = ms - acq;
    tl   = CNT_W'(tail_i);
    half_o  = h;
    setup_o = (ms > acq && diff > h) ? diff : h;
    tail_o  = (tl > h) ? tl : h;
  end
endmodule

// File: rtl/sar_shift.sv
`timescale 1ns/1ps
module sar_shift #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_o <= '0;
    else if (clr_i) word_o <= '0;
    else if (en_i)  word_o <= {word_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/sar_rd_ctrl.sv
`timescale 1ns/1ps
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SAMP_W = 10,
  parameter int TAIL_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          res_i,
  input  logic [DIV_W-1:0]    half_i,
  input  logic [SAMP_W-1:0]   min_samp_i,
  input  logic [TAIL_W-1:0]   tail_i,
  input  logic                sdo_i,
  output logic                cs_no,
  output logic                sclk_o,
  output logic                busy_o,
  output logic                valid_o,
  output logic [MAX_BITS-1:0] data_o
);
  localparam int DATA_W = MAX_BITS;
  localparam int A_W    = (SAMP_W > DIV_W + 2) ? SAMP_W : DIV_W + 2;
  localparam int CNT_W  = ((A_W > TAIL_W) ? A_W : TAIL_W) + 1;
  localparam int PH_W   = $clog2(2 * (MAX_BITS + 3));

  sar_st_e          st_q;
  logic [CNT_W-1:0] cnt_q, h_q, tail_q, h_c, setup_c, tail_c;
  logic [PH_W-1:0]  ph_q, ph_hi, ph_last;
  logic [3:0]       bits_q;
  logic [DATA_W-1:0] word;
  logic             tick, take, shift_en;

  sar_cfg #(.DIV_W(DIV_W), .SAMP_W(SAMP_W), .TAIL_W(TAIL_W), .CNT_W(CNT_W)) cfg_i (
    .half_i(half_i), .min_samp_i(min_samp_i), .tail_i(tail_i),
    .half_o(h_c), .setup_o(setup_c), .tail_o(tail_c)
  );

  assign tick    = (cnt_q == '0);
  assign take    = (st_q == ST_IDLE) && start_i;
  assign ph_hi   = PH_W'({bits_q, 1'b0}) + PH_W'(4);
  assign ph_last = ph_hi + PH_W'(1);
  // rising sclk edge of conversion periods 2..B+1
  assign shift_en = (st_q == ST_SHIFT) && tick && !ph_q[0] &&
                    (ph_q >= PH_W'(6)) && (ph_q <= ph_hi);

  sar_shift #(.DATA_W(DATA_W)) shift_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(take), .en_i(shift_en),
    .bit_i(sdo_i), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cs_no   <= 1'b1;
      sclk_o  <= 1'b1;
      valid_o <= 1'b0;
      data_o  <= '0;
      cnt_q   <= '0;
      ph_q    <= '0;
      h_q     <= CNT_W'(1);
      tail_q  <= CNT_W'(1);
      bits_q  <= 4'd12;
    end else begin
      valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SETUP;
          cs_no  <= 1'b0;
          cnt_q  <= setup_c - CNT_W'(1);
          h_q    <= h_c;
          tail_q <= tail_c;
          bits_q <= res_bits(res_i);
        end
        ST_SETUP: if (tick) begin
          st_q   <= ST_SHIFT;
          sclk_o <= 1'b0;
          ph_q   <= '0;
          cnt_q  <= h_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_SHIFT: if (tick) begin
          if (ph_q == ph_last) begin
            st_q    <= ST_TAIL;
            cs_no   <= 1'b1;
            valid_o <= 1'b1;
            data_o  <= word;
            cnt_q   <= tail_q - CNT_W'(1);
          end else begin
            ph_q   <= ph_q + PH_W'(1);
            sclk_o <= ~sclk_o;
            cnt_q  <= h_q - CNT_W'(1);
          end
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: if (tick) st_q <= ST_IDLE;
                 else cnt_q <= cnt_q - CNT_W'(1);
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);
  assert_valid_at_cs_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));
  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_busy_cover_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(!busy_o));
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$fell(cs_no)) |-> ($stable(h_q) && $stable(bits_q) && $stable(tail_q)));
endmodule

// File: tb/sar_rd_ctrl_tb.sv
`timescale 1ns/1ps
module sar_rd_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  res_i = 2'd0;
  logic [7:0]  half_i = 8'd1;
  logic [9:0]  min_samp_i = 10'd0;
  logic [7:0]  tail_i = 8'd0;
  logic        sdo_i = 1'b0;
  logic        cs_no, sclk_o, busy_o, valid_o;
  logic [11:0] data_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [11:0] mdl_word = '0;
  int mdl_bits = 12;
  int fcnt = 0;

  always #2.5 clk_i = ~clk_i;

  sar_rd_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .res_i(res_i),
    .half_i(half_i), .min_samp_i(min_samp_i), .tail_i(tail_i), .sdo_i(sdo_i),
    .cs_no(cs_no), .sclk_o(sclk_o), .busy_o(busy_o), .valid_o(valid_o),
    .data_o(data_o)
  );

  // behavioural converter: zero after the hold edge, then MSB first
  always @(negedge cs_no) fcnt = 0;
  always @(negedge sclk_o) begin
    fcnt = fcnt + 1;
    if (fcnt >= 4 && fcnt - 4 < mdl_bits) sdo_i = mdl_word[mdl_bits - 1 - (fcnt - 4)];
    else sdo_i = 1'b0;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int res, input int h, input int ms, input int tl,
                     input logic [11:0] word, input bit disturb);
    int bits, he, s, t, cslow, setup, falls, lowrun, lowbad, idlebad, vcnt, vbad;
    int tailc, csf, n, got;
    bit psclk, pcs, dist_done;
    bits = (res == 0) ? 12 : (res == 1) ? 10 : 8;
    he = (h == 0) ? 1 : h;
    s = (ms - 4 * he > he) ? ms - 4 * he : he;
    t = (tl > he) ? tl : he;
    res_i = 2'(res); half_i = 8'(h); min_samp_i = 10'(ms); tail_i = 8'(tl);
    mdl_word = word; mdl_bits = bits;
    cslow = 0; setup = 0; falls = 0; lowrun = 0; lowbad = 0; idlebad = 0;
    vcnt = 0; vbad = 0; tailc = 0; csf = 0; n = 0; got = -1;
    psclk = 1'b1; pcs = 1'b1; dist_done = 1'b0;
    @(negedge clk_i) start_i = 1'b1;
    forever begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (pcs && !cs_no) csf++;
      if (!cs_no) cslow++;
      if (!cs_no && falls == 0 && sclk_o) setup++;
      if (psclk && !sclk_o) falls++;
      if (!sclk_o) lowrun++;
      else if (!psclk) begin if (lowrun != he) lowbad++; lowrun = 0; end
      if (cs_no && !sclk_o) idlebad++;
      if (valid_o) begin vcnt++; if (!(cs_no && !pcs)) vbad++; got = int'(data_o); end
      if (cs_no && busy_o) tailc++;
      if (disturb && falls == 1 && !dist_done) begin
        dist_done = 1'b1; start_i = 1'b1;
        res_i = ~res_i; half_i = half_i + 8'd2; tail_i = tail_i + 8'd5;
        min_samp_i = min_samp_i + 10'd40;
      end
      psclk = sclk_o; pcs = cs_no; n++;
      if (!busy_o || n > 3000) break;
    end
    chk(setup == s, disturb ? "R9 setup" : "R3 setup cycles", setup, s);
    chk(s + 4 * he >= ms, "R3 acquisition", s + 4 * he, ms);
    chk(falls == bits + 3, disturb ? "R9 falls" : "R4 sclk falls", falls, bits + 3);
    chk(lowbad == 0 && idlebad == 0, "R2 sclk phases", lowbad + idlebad, 0);
    chk(got == int'(word & 12'((1 << bits) - 1)), disturb ? "R9 data" : "R5 data",
        got, int'(word & 12'((1 << bits) - 1)));
    chk(cslow == s + 2 * he * (bits + 3), "R6 cs low", cslow, s + 2 * he * (bits + 3));
    chk(vcnt == 1 && vbad == 0, "R6 valid pulse", vcnt * 10 + vbad, 10);
    chk(tailc == t, disturb ? "R9 tail" : "R7 tail", tailc, t);
    chk(csf == 1, "R8 single cs fall", csf, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(cs_no && !busy_o, "R8 stays idle", int'({cs_no, busy_o}), 2);
    end
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk_i);
    chk(cs_no && sclk_o && !busy_o && !valid_o && data_o == 0, "R1 in reset",
        int'({cs_no, sclk_o, busy_o, valid_o}), 12);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no && sclk_o && !busy_o && !valid_o && data_o == 0, "R1 after reset",
        int'({cs_no, sclk_o, busy_o, valid_o}), 12);
    for (int r = 0; r < 4; r++)
      for (int hi = 0; hi < 3; hi++)
        for (int mi = 0; mi < 3; mi++)
          for (int ti = 0; ti < 3; ti++) begin
            int hv, mv, tv;
            hv = (hi == 0) ? 0 : (hi == 1) ? 1 : 3;
            mv = (mi == 0) ? 0 : (mi == 1) ? 9 : 30;
            tv = (ti == 0) ? 0 : (ti == 1) ? 2 : 9;
            run(r, hv, mv, tv, 12'hA5C ^ 12'(k * 37), (k % 5) == 2);
            k++;
          end
    run(0, 2, 0, 0, 12'hFFF, 1'b0);
    run(0, 2, 0, 0, 12'h000, 1'b1);
    run(2, 1, 3, 1, 12'h081, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule